// File: doc/BRIEF.md
# Two-Stage Image-Rejection Digital Downconverter

The block takes a pair of 1-bit samples, an in-phase and a quadrature channel taken 90 degrees apart, and shifts the signal to baseband in two complex mixing steps. Each step has its own phase accumulator. The first step uses a coarse three-level local oscillator to remove a large fixed frequency offset. Because both the input and this local signal have a single sign bit, this mixer reduces to XOR gates. The second step uses a fifteen-level local oscillator for fine carrier tracking. It produces 5-bit signed I and Q words.

Software writes the frequency words (phase increments) through write strobes. A write stays pending until the next parameter-period strobe. On that strobe the pending word becomes active and the phase of each accumulator is captured for readout. A mode input conjugates both local oscillators, so the same datapath shifts the spectrum upward instead of down. Each output carries a blank flag. The flag tells a downstream integrator that no term contributed to that sample and that the sample should be skipped.

Top module: `irm_downconv`

## Requirements
- R1: While `rst_n` is low, both accumulators, both pending and active increments, and both snapshots clear to zero. Both outputs clear to 0 with their blank flags set.
- R2: On every clock edge with `smp_en` high, each accumulator adds its active increment modulo 2^N (N = 24 for the first stage, 32 for the second). With `smp_en` low, it holds its value.
- R3: A write to an increment only updates the pending word. The pending word becomes active at the next edge with `period_stb` high. A write in the same cycle as the strobe takes effect at that strobe. An active increment changes the accumulator only from the following edge onward.
- R4: On an edge with `period_stb` high, each snapshot output captures the accumulator value present before that edge. The snapshot holds until the next strobe.
- R5: The coarse oscillator is indexed by octant k, the top 3 accumulator bits. Its cosine is +1 for k = 0, 1, 7, is 0 for k = 2, 6, and is -1 otherwise. Its sine is 0 for k = 0, 4, is +1 for k = 1, 2, 3, and is -1 otherwise.
- R6: An input bit of 1 means -1 and a bit of 0 means +1. With the coarse cosine c and sine s, the first stage forms a = xi·c + xq·s and b = xq·c − xi·s. Only the sign of each result is passed on, and a zero result marks that intermediate sample as blank.
- R7: The fine oscillator is indexed by m, the top 6 accumulator bits. Its sine is round(7·sin(2π(m+0.5)/64)) and its cosine is the sine at index (m+16) mod 64, both held as 4-bit two's complement values.
- R8: On an edge with `smp_en` high, the outputs load the following values, where I1 and Q1 are the first-stage ternary values and C and S are the fine cosine and sine: `out_i` = I1·C + Q1·S and `out_q` = Q1·C − I1·S, as 5-bit two's complement. Both stages use the accumulator values from before that edge. The outputs hold while `smp_en` is low.
- R9: `out_i_blank` is set when both terms of `out_i` vanish, meaning (I1 blank or C = 0) and (Q1 blank or S = 0). `out_q_blank` is set when (Q1 blank or C = 0) and (I1 blank or S = 0). A blank output is 0.
- R10: With `up_mode` high, the sine of both oscillators is negated before mixing, which turns the block into an up-converter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sample-rate enable, one pulse per input sample |
| in_i | input | 1 | In-phase input sample, 1 = negative |
| in_q | input | 1 | Quadrature input sample, 1 = negative |
| up_mode | input | 1 | 1 selects up-conversion |
| period_stb | input | 1 | Parameter-period strobe |
| inc1_wr | input | 1 | Write strobe for the coarse increment |
| inc1_data | input | 24 | Coarse increment value |
| inc2_wr | input | 1 | Write strobe for the fine increment |
| inc2_data | input | 32 | Fine increment value |
| phase1_snap | output | 24 | Captured coarse phase |
| phase2_snap | output | 32 | Captured fine phase |
| out_i | output | 5 | Mixed in-phase sample, signed |
| out_q | output | 5 | Mixed quadrature sample, signed |
| out_i_blank | output | 1 | No term contributed to `out_i` |
| out_q_blank | output | 1 | No term contributed to `out_q` |

## Verification
The mixed outputs come from one register. They are due at the first rising edge with `smp_en` high after the inputs are applied, and they use the phases present before that edge. The snapshots likewise settle at the strobe edge. A new increment appears in the accumulator, and so in a later snapshot, only from the edge after its strobe. The bench drives every input on a falling edge and steps its reference model for exactly one rising edge. It then compares all six outputs at the next falling edge, so each result is read one edge after its stimulus.

// File: rtl/irm_pkg.sv
// Shared types and table functions for the two-stage image-rejection mixer.
// Assumes a 3-bit octant index for the coarse table and a 6-bit index for
// the fine table (fifteen levels, amplitude 7).
package irm_pkg;

    // Ternary local sample: neg = sign, mag = 0 marks a blank (zero) value.
    typedef struct packed {
        logic neg;
        logic mag;
    } tern_t;

    localparam int COARSE_IDX_W = 3;
    localparam int FINE_IDX_W   = 6;
    localparam int FINE_LVL_W   = 4;

    // One quarter wave of the fine table: round(7*sin(2*pi*(j+0.5)/64)).
    function automatic logic [2:0] fine_quarter(input logic [3:0] j);
        logic [2:0] v;
        case (j)
            4'd0:                      v = 3'd0;
            4'd1:                      v = 3'd1;
            4'd2, 4'd3:                v = 3'd2;
            4'd4:                      v = 3'd3;
            4'd5, 4'd6:                v = 3'd4;
            4'd7, 4'd8:                v = 3'd5;
            4'd9, 4'd10, 4'd11:        v = 3'd6;
            default:                   v = 3'd7;
        endcase
        return v;
    endfunction

    // Full-wave fine sine from a 6-bit index by quadrant symmetry.
    function automatic logic signed [FINE_LVL_W-1:0] fine_sine(input logic [5:0] m);
        logic [2:0] mag;
        mag = m[4] ? fine_quarter(4'd15 - m[3:0]) : fine_quarter(m[3:0]);
        return m[5] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    endfunction

endpackage

// File: rtl/irm_nco.sv
// Phase accumulator with a double-buffered increment and a phase snapshot.
// Writes land in a pending word; the period strobe activates it and
// captures the current phase. The accumulator wraps modulo 2^W.
module irm_nco #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         period_stb,
    input  logic         inc_wr,
    input  logic [W-1:0] inc_data,
    output logic [W-1:0] phase,
    output logic [W-1:0] snap
);

    logic [W-1:0] inc_pend;
    logic [W-1:0] inc_act;
    logic [W-1:0] acc;
    logic [W-1:0] snap_q;

    // Pending increment: latches every software write.
    always_ff @(posedge clk) begin
        if (!rst_n)      inc_pend <= '0;
        else if (inc_wr) inc_pend <= inc_data;
    end

    // Active increment: takes the newest word on the period strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          inc_act <= '0;
        else if (period_stb) inc_act <= inc_wr ? inc_data : inc_pend;
    end

    // Phase accumulator: advances once per sample tick, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (adv) acc <= acc + inc_act;
    end

    // Snapshot: holds the phase seen at the last period strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          snap_q <= '0;
        else if (period_stb) snap_q <= acc;
    end

    assign phase = acc;
    assign snap  = snap_q;

endmodule

// File: rtl/irm_stage1.sv
// Coarse image-rejection mixer. A three-level cosine/sine from the top
// 3 phase bits multiplies the 1-bit I/Q samples by XOR on the sign bits.
// Only the sign and a blank flag of each combined result leave the stage.
// Purely combinational; the caller registers the result.
module irm_stage1
    import irm_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [W-1:0] phase,
    input  logic         in_i,
    input  logic         in_q,
    input  logic         up_mode,
    output logic         i_neg,
    output logic         i_blank,
    output logic         q_neg,
    output logic         q_blank
);

    logic [COARSE_IDX_W-1:0] oct;
    tern_t                   lo_c;
    tern_t                   lo_s;
    logic signed [2:0]       sum_i;
    logic signed [2:0]       sum_q;

    assign oct = phase[W-1 -: COARSE_IDX_W];

    // One ternary product: XOR of signs, gated by the local magnitude.
    function automatic logic signed [2:0] tprod(input logic x, input tern_t lo);
        if (!lo.mag)          return 3'sd0;
        else if (x ^ lo.neg)  return -3'sd1;
        else                  return 3'sd1;
    endfunction

    // Coarse table lookup; up-conversion flips the sine sign.
    always_comb begin
        lo_c.mag = !(oct == 3'd2 || oct == 3'd6);
        lo_c.neg = (oct == 3'd3 || oct == 3'd4 || oct == 3'd5);
        lo_s.mag = !(oct == 3'd0 || oct == 3'd4);
        lo_s.neg = (oct == 3'd5 || oct == 3'd6 || oct == 3'd7) ^ up_mode;
    end

    // Image-rejection combination and reduction to sign plus blank.
    always_comb begin
        sum_i   = tprod(in_i, lo_c) + tprod(in_q, lo_s);
        sum_q   = tprod(in_q, lo_c) - tprod(in_i, lo_s);
        i_neg   = sum_i[2];
        i_blank = (sum_i == 3'sd0);
        q_neg   = sum_q[2];
        q_blank = (sum_q == 3'sd0);
    end

endmodule

// File: rtl/irm_stage2.sv
// Fine image-rejection mixer with the output register. A fifteen-level
// cosine/sine from the top 6 phase bits multiplies the ternary stage-1
// values; sums and differences form the signed I/Q words. Assumes OUT_W
// is at least 5 so the largest magnitude (14) fits.
module irm_stage2
    import irm_pkg::*;
#(
    parameter int W     = 32,
    parameter int OUT_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic [W-1:0]            phase,
    input  logic                    up_mode,
    input  logic                    i_neg,
    input  logic                    i_blank,
    input  logic                    q_neg,
    input  logic                    q_blank,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q,
    output logic                    out_i_blank,
    output logic                    out_q_blank
);

    localparam logic [FINE_IDX_W-1:0] QTR = FINE_IDX_W'(1 << (FINE_IDX_W - 2));

    logic [FINE_IDX_W-1:0]        idx;
    logic signed [FINE_LVL_W-1:0] lo_c;
    logic signed [FINE_LVL_W-1:0] lo_s;
    logic signed [OUT_W-1:0]      nxt_i;
    logic signed [OUT_W-1:0]      nxt_q;
    logic                         nxt_bi;
    logic                         nxt_bq;

    assign idx = phase[W-1 -: FINE_IDX_W];

    // Ternary value times a fine local level, sign-extended to OUT_W.
    function automatic logic signed [OUT_W-1:0] fprod(input logic neg, input logic blank,
                                                      input logic signed [FINE_LVL_W-1:0] lo);
        logic signed [OUT_W-1:0] ext;
        ext = {{(OUT_W-FINE_LVL_W){lo[FINE_LVL_W-1]}}, lo};
        if (blank)    return '0;
        else if (neg) return -ext;
        else          return ext;
    endfunction

    // Fine table lookup; cosine is the sine a quarter turn ahead.
    always_comb begin
        lo_c = fine_sine(idx + QTR);
        lo_s = up_mode ? -fine_sine(idx) : fine_sine(idx);
    end

    // Image-rejection combination and per-lane blank detection.
    always_comb begin
        nxt_i  = fprod(i_neg, i_blank, lo_c) + fprod(q_neg, q_blank, lo_s);
        nxt_q  = fprod(q_neg, q_blank, lo_c) - fprod(i_neg, i_blank, lo_s);
        nxt_bi = (i_blank || lo_c == '0) && (q_blank || lo_s == '0);
        nxt_bq = (q_blank || lo_c == '0) && (i_blank || lo_s == '0);
    end

    // Output register: loads once per sample tick, idles blank after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_i       <= '0;
            out_q       <= '0;
            out_i_blank <= 1'b1;
            out_q_blank <= 1'b1;
        end else if (adv) begin
            out_i       <= nxt_i;
            out_q       <= nxt_q;
            out_i_blank <= nxt_bi;
            out_q_blank <= nxt_bq;
        end
    end

endmodule

// File: rtl/irm_downconv.sv
// Top of the two-stage image-rejection converter: two phase accumulators,
// a coarse XOR mixer and a fine multi-level mixer with registered outputs.
// Assumes smp_en pulses once per input sample and period_stb once per period.
module irm_downconv #(
    parameter int PH1_W = 24,
    parameter int PH2_W = 32,
    parameter int OUT_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    in_i,
    input  logic                    in_q,
    input  logic                    up_mode,
    input  logic                    period_stb,
    input  logic                    inc1_wr,
    input  logic [PH1_W-1:0]        inc1_data,
    input  logic                    inc2_wr,
    input  logic [PH2_W-1:0]        inc2_data,
    output logic [PH1_W-1:0]        phase1_snap,
    output logic [PH2_W-1:0]        phase2_snap,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q,
    output logic                    out_i_blank,
    output logic                    out_q_blank
);

    logic [PH1_W-1:0] ph1;
    logic [PH2_W-1:0] ph2;
    logic             s1_i_neg;
    logic             s1_i_blank;
    logic             s1_q_neg;
    logic             s1_q_blank;

    irm_nco #(.W(PH1_W)) u_nco1 (
        .clk(clk), .rst_n(rst_n), .adv(smp_en), .period_stb(period_stb),
        .inc_wr(inc1_wr), .inc_data(inc1_data), .phase(ph1), .snap(phase1_snap)
    );

    irm_nco #(.W(PH2_W)) u_nco2 (
        .clk(clk), .rst_n(rst_n), .adv(smp_en), .period_stb(period_stb),
        .inc_wr(inc2_wr), .inc_data(inc2_data), .phase(ph2), .snap(phase2_snap)
    );

    irm_stage1 #(.W(PH1_W)) u_st1 (
        .phase(ph1), .in_i(in_i), .in_q(in_q), .up_mode(up_mode),
        .i_neg(s1_i_neg), .i_blank(s1_i_blank), .q_neg(s1_q_neg), .q_blank(s1_q_blank)
    );

    irm_stage2 #(.W(PH2_W), .OUT_W(OUT_W)) u_st2 (
        .clk(clk), .rst_n(rst_n), .adv(smp_en), .phase(ph2), .up_mode(up_mode),
        .i_neg(s1_i_neg), .i_blank(s1_i_blank), .q_neg(s1_q_neg), .q_blank(s1_q_blank),
        .out_i(out_i), .out_q(out_q), .out_i_blank(out_i_blank), .out_q_blank(out_q_blank)
    );

endmodule

// File: rtl/irm_downconv_chk.sv
// Checker for irm_downconv: holding behaviour, output range and blank
// consistency, attached to every instance by the bind below.
module irm_downconv_chk #(
    parameter int W1    = 24,
    parameter int W2    = 32,
    parameter int OUT_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_en,
    input logic                    period_stb,
    input logic [W1-1:0]           acc1,
    input logic [W2-1:0]           acc2,
    input logic [W1-1:0]           phase1_snap,
    input logic [W2-1:0]           phase2_snap,
    input logic signed [OUT_W-1:0] out_i,
    input logic signed [OUT_W-1:0] out_q,
    input logic                    out_i_blank,
    input logic                    out_q_blank
);

    // R2: accumulators stay put without a sample tick.
    assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> ($stable(acc1) && $stable(acc2)));

    // R4: a snapshot changes only on a period strobe.
    assert_snap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !period_stb |=> ($stable(phase1_snap) && $stable(phase2_snap)));

    // R4: a strobe captures the fine phase of the cycle before.
    assert_snap_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |=> (phase2_snap == $past(acc2)));

    // R8: outputs hold between sample ticks.
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> ($stable(out_i) && $stable(out_q) && $stable(out_i_blank) && $stable(out_q_blank)));

    // R8: mixed words never exceed two full-scale terms.
    assert_out_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(out_i) >= -14 && $signed(out_i) <= 14 && $signed(out_q) >= -14 && $signed(out_q) <= 14));

    // R9: a blank output carries zero.
    assert_blank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((!out_i_blank || out_i == '0) && (!out_q_blank || out_q == '0)));

endmodule

bind irm_downconv irm_downconv_chk #(.W1(PH1_W), .W2(PH2_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .period_stb(period_stb),
    .acc1(ph1), .acc2(ph2), .phase1_snap(phase1_snap), .phase2_snap(phase2_snap),
    .out_i(out_i), .out_q(out_q), .out_i_blank(out_i_blank), .out_q_blank(out_q_blank)
);

// File: tb/sim_irm_downconv.sv
`timescale 1ns/1ps
module sim_irm_downconv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0, in_i = 1'b0, in_q = 1'b0, up_mode = 1'b0, period_stb = 1'b0;
    logic        inc1_wr = 1'b0, inc2_wr = 1'b0;
    logic [23:0] inc1_data = '0;
    logic [31:0] inc2_data = '0;
    logic [23:0] phase1_snap;
    logic [31:0] phase2_snap;
    logic signed [4:0] out_i, out_q;
    logic        out_i_blank, out_q_blank;

    int checks = 0, fails = 0;
    logic [23:0] m_acc1 = '0, m_pend1 = '0, m_act1 = '0, m_snap1 = '0;
    logic [31:0] m_acc2 = '0, m_pend2 = '0, m_act2 = '0, m_snap2 = '0;
    int e_i = 0, e_q = 0;
    bit e_bi = 1'b1, e_bq = 1'b1;

    always #2.5 clk = ~clk;

    irm_downconv u0 (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .in_i(in_i), .in_q(in_q),
        .up_mode(up_mode), .period_stb(period_stb), .inc1_wr(inc1_wr), .inc1_data(inc1_data),
        .inc2_wr(inc2_wr), .inc2_data(inc2_data), .phase1_snap(phase1_snap),
        .phase2_snap(phase2_snap), .out_i(out_i), .out_q(out_q),
        .out_i_blank(out_i_blank), .out_q_blank(out_q_blank)
    );

    task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference tables written from the requirement text.
    function automatic int tcos(input int k);
        if (k == 0 || k == 1 || k == 7) return 1;
        if (k == 2 || k == 6) return 0;
        return -1;
    endfunction
    function automatic int tsin(input int k);
        if (k == 0 || k == 4) return 0;
        if (k >= 1 && k <= 3) return 1;
        return -1;
    endfunction
    function automatic int lvl(input int m);
        real x;
        x = 7.0 * $sin(2.0 * 3.14159265358979 * (real'(m) + 0.5) / 64.0);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction
    function automatic int sg(input logic b);
        return b ? -1 : 1;
    endfunction
    function automatic int sgn(input int a);
        return (a > 0) ? 1 : ((a < 0) ? -1 : 0);
    endfunction

    // Expected outputs for the current model phases and given inputs.
    task automatic model_out(input logic xi, input logic xq, input logic up);
        int k, m, c1, s1, i1, q1, c2, s2;
        k  = int'(m_acc1[23:21]);
        m  = int'(m_acc2[31:26]);
        c1 = tcos(k);
        s1 = up ? -tsin(k) : tsin(k);
        i1 = sgn(sg(xi) * c1 + sg(xq) * s1);
        q1 = sgn(sg(xq) * c1 - sg(xi) * s1);
        c2 = lvl((m + 16) % 64);
        s2 = up ? -lvl(m) : lvl(m);
        e_i  = i1 * c2 + q1 * s2;
        e_q  = q1 * c2 - i1 * s2;
        e_bi = (i1 == 0 || c2 == 0) && (q1 == 0 || s2 == 0);
        e_bq = (q1 == 0 || c2 == 0) && (i1 == 0 || s2 == 0);
    endtask

    // One clock: drive at the falling edge, advance the model, compare after.
    task automatic step(input bit en, input bit stb, input bit w1, input logic [23:0] d1,
                        input bit w2, input logic [31:0] d2, input bit xi, input bit xq,
                        input bit up, input string tag);
        string t_out, t_bl, t_sn;
        smp_en = en; period_stb = stb; inc1_wr = w1; inc1_data = d1;
        inc2_wr = w2; inc2_data = d2; in_i = xi; in_q = xq; up_mode = up;
        if (en) model_out(xi, xq, up);
        if (stb) begin
            m_snap1 = m_acc1; m_snap2 = m_acc2;
            m_act1n(w1, d1, w2, d2);
        end
        if (w1) m_pend1 = d1;
        if (w2) m_pend2 = d2;
        @(posedge clk);
        @(negedge clk);
        t_out = (tag == "") ? "R8" : tag;
        t_bl  = (tag == "") ? "R9" : tag;
        t_sn  = (tag == "") ? "R4" : tag;
        check(int'(out_i) == e_i, t_out, "out_i", out_i, e_i);
        check(int'(out_q) == e_q, t_out, "out_q", out_q, e_q);
        check(out_i_blank == e_bi, t_bl, "out_i_blank", out_i_blank, e_bi);
        check(out_q_blank == e_bq, t_bl, "out_q_blank", out_q_blank, e_bq);
        check(phase1_snap == m_snap1, t_sn, "phase1_snap", phase1_snap, m_snap1);
        check(phase2_snap == m_snap2, t_sn, "phase2_snap", phase2_snap, m_snap2);
    endtask

    // Accumulate with the old active word, then activate the new one.
    logic [23:0] nxt_act1;
    logic [31:0] nxt_act2;
    task automatic m_act1n(input bit w1, input logic [23:0] d1, input bit w2, input logic [31:0] d2);
        nxt_act1 = w1 ? d1 : m_pend1;
        nxt_act2 = w2 ? d2 : m_pend2;
    endtask

    task automatic tick(input bit en, input bit stb, input bit w1, input logic [23:0] d1,
                        input bit w2, input logic [31:0] d2, input bit xi, input bit xq,
                        input bit up, input string tag);
        logic [23:0] a1;
        logic [31:0] a2;
        a1 = m_act1; a2 = m_act2;
        nxt_act1 = m_act1; nxt_act2 = m_act2;
        step(en, stb, w1, d1, w2, d2, xi, xq, up, tag);
        if (en) begin
            m_acc1 = m_acc1 + a1;
            m_acc2 = m_acc2 + a2;
        end
        m_act1 = nxt_act1; m_act2 = nxt_act2;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E3D);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values.
        check(out_i == 0 && out_q == 0, "R1", "out after reset", out_i, 0);
        check(out_i_blank && out_q_blank, "R1", "blanks after reset", out_i_blank, 1);
        check(phase1_snap == 0, "R1", "snap1 after reset", phase1_snap, 0);
        check(phase2_snap == 0, "R1", "snap2 after reset", phase2_snap, 0);
        for (int n = 0; n < 4; n++) tick(1, n == 3, 0, '0, 0, '0, n[0], n[1], 0, "R1");

        // R2: wrapping increments, with gaps in the enable.
        tick(0, 1, 1, 24'hFFFFFF, 1, 32'h8000_0001, 0, 0, 0, "R2");
        for (int n = 0; n < 40; n++) tick(n % 5 != 4, n % 7 == 6, 0, '0, 0, '0, n[0], n[2], 0, "R2");

        // R3: writes stay pending until the strobe.
        tick(1, 0, 1, 24'h012345, 1, 32'h0ABC_DEF1, 1, 0, 0, "R3");
        for (int n = 0; n < 6; n++) tick(1, n == 5, 0, '0, 0, '0, 0, 1, 0, "R3");
        for (int n = 0; n < 6; n++) tick(1, n == 5, 0, '0, 0, '0, 1, 1, 0, "R3");

        // R5/R6: one coarse octant per sample, every input pair.
        tick(0, 1, 1, 24'h200000, 1, 32'h0, 0, 0, 0, "R5");
        for (int n = 0; n < 32; n++) tick(1, 0, 0, '0, 0, '0, n[3], n[4], 0, "R5");
        for (int n = 0; n < 64; n++) tick(1, n % 16 == 0, 0, '0, 0, '0, n[0], n[1], n[5], "R6");

        // R7: one fine table entry per sample.
        tick(0, 1, 1, 24'h0, 1, 32'h0400_0000, 0, 0, 0, "R7");
        for (int n = 0; n < 130; n++) tick(1, 0, 0, '0, 0, '0, n[6], n[7], 0, "R7");

        // R10: up-conversion with random frequencies and samples.
        tick(0, 1, 1, 24'h1A3C5E, 1, 32'h0312_4567, 0, 0, 1, "R10");
        for (int n = 0; n < 200; n++) begin
            logic [1:0] r;
            r = 2'($urandom);
            tick(1, 0, 0, '0, 0, '0, r[0], r[1], 1, "R10");
        end

        // R9: blanks with stage-1 cancellations and zero fine levels.
        tick(0, 1, 1, 24'h100000, 1, 32'h0200_0000, 0, 0, 0, "R9");
        for (int n = 0; n < 128; n++) tick(1, 0, 0, '0, 0, '0, n[0], n[1] ^ n[3], 0, "R9");

        // Random mix of everything.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            tick(r[1:0] != 0, r[6:2] == 0, r[11:7] == 0, 24'($urandom), r[16:12] == 0, $urandom,
                 r[17], r[18], r[24:20] < 3, "");
        end
        finish_run();
    end

endmodule